// File: doc/BRIEF.md
# Interrupt Vector Priority Controller

This block holds the interrupt state of one processor core for 256 vectors. Three bitmaps are kept: vectors waiting for service, vectors currently being serviced, and the trigger type (level or edge) that each waiting vector arrived with. The processor priority is derived from a task priority register and the most important vector in service. A waiting vector is put forward to the core only when its priority class outranks that processor priority.

Interrupt sources present a vector and its trigger mode on the accept port and learn at once whether the request was taken. Software sets the task priority either as a full byte or through a 4-bit class-only view. The core takes the vector on offer with an acknowledge strobe and retires it with an end-of-interrupt strobe. The end-of-interrupt strobe reports which vector was retired and whether it was level triggered, so that a level source can be re-armed.

Top module: `vprio_ctrl`

## Requirements
- R1: The offered vector is the numerically highest pending vector. Priority class is bits [7:4] of the vector, and the search covers all 256 vectors, across every 32-vector word boundary.
- R2: When a vector is in service, the processor priority equals the full task priority if task priority bits [7:4] are greater than or equal to bits [7:4] of the highest in-service vector. Otherwise it equals that vector's bits [7:4] with bits [3:0] zero.
- R3: When no vector is in service, the processor priority equals the full task priority.
- R4: A pending vector is offered only when its class (bits [7:4], with bits [3:0] zero) is strictly greater than the processor priority.
- R5: An acknowledge while a vector is offered returns that vector with ack_valid high. In the next cycle the vector is in service and no longer pending.
- R6: An acknowledge while nothing is offered returns ack_valid low and changes no state.
- R7: An accept of a vector that is already pending returns acc_ok low and leaves that vector's trigger mode unchanged. A successful accept records level mode (acc_level=1) or edge mode (acc_level=0) for that vector.
- R8: An end-of-interrupt with nothing in service returns eoi_valid low and changes no state.
- R9: An end-of-interrupt retires the highest in-service vector and reports it with its recorded trigger mode. The processor priority is then recomputed and the trigger record is cleared.
- R10: A write to the 4-bit class view sets task priority bits [7:4] to the written value, keeps task priority bit 2, and clears bits 3, 1 and 0. The class view reads back task priority bits [7:4]. A full-byte write takes precedence over a class-view write in the same cycle.
- R11: While enable is low, nothing is offered, an acknowledge grants nothing, and accepts are refused without recording the vector.
- R12: Reset clears all three bitmaps and the task priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Controller enabled |
| acc_valid | input | 1 | Accept request strobe |
| acc_vec | input | 8 | Vector to accept |
| acc_level | input | 1 | 1 = level triggered, 0 = edge |
| acc_ok | output | 1 | Request taken (combinational) |
| tpr_wr | input | 1 | Full task priority write |
| tpr_wdata | input | 8 | Task priority value |
| cr_wr | input | 1 | Class-view write |
| cr_wdata | input | 4 | Class-view value |
| cr_rdata | output | 4 | Class-view read value |
| task_prio | output | 8 | Current task priority |
| proc_prio | output | 8 | Current processor priority |
| offer_valid | output | 1 | A vector qualifies for delivery |
| offer_vec | output | 8 | Vector on offer |
| ack | input | 1 | Acknowledge strobe |
| ack_valid | output | 1 | Acknowledge granted a vector |
| ack_vec | output | 8 | Granted vector |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_valid | output | 1 | A vector was retired |
| eoi_vec | output | 8 | Retired vector |
| eoi_level | output | 1 | Retired vector was level triggered |

## Verification
The hardest state to reach is a vector that sits in service while the task priority is changed to values on both sides of its class. That requires a pending vector to be accepted, made to qualify and acknowledged before the task priority writes begin. The stimulus table builds this order step by step: it raises the task priority until the offer disappears, lowers it by one so that the vector is offered again, and acknowledges it. It then walks the task priority above, below and back across the in-service class. The trigger record is checked indirectly. A repeated level accept on an edge vector is followed later by that vector's retirement, which must still report edge mode.

// File: rtl/vprio_pkg.sv
// Shared constants for the vector priority controller.
// Assumes an 8-bit vector whose upper four bits form the priority class.
package vprio_pkg;
    localparam int VEC_W   = 8;
    localparam int CLASS_W = 4;
    localparam int WORD_W  = 32;
    localparam int KEEP_BIT = 2;
endpackage

// File: rtl/vprio_find.sv
// Highest-set-bit finder over a wide map, organised as words.
// Each word resolves its top bit locally; the highest non-empty word wins.
// Assumes NUM is a multiple of WORD_W and both are powers of two.
module vprio_find #(
    parameter int NUM    = 256,
    parameter int WORD_W = 32
) (
    input  logic [NUM-1:0]         map,
    output logic                   found,
    output logic [$clog2(NUM)-1:0] idx
);
    localparam int NWORDS = NUM / WORD_W;
    localparam int IDX_W  = $clog2(NUM);
    localparam int BIT_W  = $clog2(WORD_W);

    logic [NWORDS-1:0]            word_hit;
    logic [NWORDS-1:0][BIT_W-1:0] word_pos;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [WORD_W-1:0] slice;
        logic [BIT_W-1:0]  pos;
        assign slice       = map[w*WORD_W +: WORD_W];
        assign word_hit[w] = |slice;
        // Top set bit within this word.
        always_comb begin
            pos = '0;
            for (int b = 0; b < WORD_W; b++)
                if (slice[b]) pos = BIT_W'(b);
        end
        assign word_pos[w] = pos;
    end

    // Pick the highest word holding a set bit.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (word_hit[w]) begin
                found = 1'b1;
                idx   = IDX_W'(w * WORD_W) + IDX_W'(word_pos[w]);
            end
        end
    end
endmodule

// File: rtl/vprio_ppr.sv
// Processor priority from task priority and the top in-service vector.
// Compares by class only; an empty in-service map counts as vector 0.
module vprio_ppr #(
    parameter int VEC_W   = 8,
    parameter int CLASS_W = 4
) (
    input  logic [VEC_W-1:0] tpr,
    input  logic             isr_found,
    input  logic [VEC_W-1:0] isr_vec,
    output logic [VEC_W-1:0] ppr
);
    localparam int LOW_W = VEC_W - CLASS_W;

    logic [VEC_W-1:0] isrv;

    // Choose between task priority and in-service class.
    always_comb begin
        isrv = isr_found ? isr_vec : '0;
        if (tpr[VEC_W-1 -: CLASS_W] >= isrv[VEC_W-1 -: CLASS_W])
            ppr = tpr;
        else
            ppr = {isrv[VEC_W-1 -: CLASS_W], {LOW_W{1'b0}}};
    end
endmodule

// File: rtl/vprio_ctrl.sv
// Interrupt vector priority controller: pending, in-service and trigger
// bitmaps, task/processor priority, offer, acknowledge and retirement.
// Assumes strobes are single-cycle; all results of a strobe are
// combinational in its cycle and the bitmaps update on the next edge.
module vprio_ctrl #(
    parameter int VEC_W    = vprio_pkg::VEC_W,
    parameter int CLASS_W  = vprio_pkg::CLASS_W,
    parameter int WORD_W   = vprio_pkg::WORD_W,
    parameter int KEEP_BIT = vprio_pkg::KEEP_BIT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               acc_valid,
    input  logic [VEC_W-1:0]   acc_vec,
    input  logic               acc_level,
    output logic               acc_ok,
    input  logic               tpr_wr,
    input  logic [VEC_W-1:0]   tpr_wdata,
    input  logic               cr_wr,
    input  logic [CLASS_W-1:0] cr_wdata,
    output logic [CLASS_W-1:0] cr_rdata,
    output logic [VEC_W-1:0]   task_prio,
    output logic [VEC_W-1:0]   proc_prio,
    output logic               offer_valid,
    output logic [VEC_W-1:0]   offer_vec,
    input  logic               ack,
    output logic               ack_valid,
    output logic [VEC_W-1:0]   ack_vec,
    input  logic               eoi,
    output logic               eoi_valid,
    output logic [VEC_W-1:0]   eoi_vec,
    output logic               eoi_level
);
    localparam int NUM   = 1 << VEC_W;
    localparam int LOW_W = VEC_W - CLASS_W;
    localparam logic [LOW_W-1:0] KEEP_MASK = LOW_W'(1) << KEEP_BIT;

    logic [NUM-1:0]   irr_q, irr_d;
    logic [NUM-1:0]   isr_q, isr_d;
    logic [NUM-1:0]   tmr_q, tmr_d;
    logic [VEC_W-1:0] tpr_q, tpr_d;
    logic             irr_found, isr_found;
    logic [VEC_W-1:0] irr_top, isr_top;
    logic [VEC_W-1:0] irr_class;

    vprio_find #(.NUM(NUM), .WORD_W(WORD_W)) i_find_irr (
        .map(irr_q), .found(irr_found), .idx(irr_top));
    vprio_find #(.NUM(NUM), .WORD_W(WORD_W)) i_find_isr (
        .map(isr_q), .found(isr_found), .idx(isr_top));
    vprio_ppr #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) i_ppr (
        .tpr(tpr_q), .isr_found(isr_found), .isr_vec(isr_top), .ppr(proc_prio));

    // Offer, acknowledge, accept and retirement results.
    always_comb begin
        irr_class   = {irr_top[VEC_W-1 -: CLASS_W], {LOW_W{1'b0}}};
        offer_valid = enable && irr_found && (irr_class > proc_prio);
        offer_vec   = irr_found ? irr_top : '0;
        ack_valid   = ack && offer_valid;
        ack_vec     = ack_valid ? irr_top : '0;
        acc_ok      = acc_valid && enable && !irr_q[acc_vec];
        eoi_valid   = eoi && isr_found;
        eoi_vec     = isr_found ? isr_top : '0;
        eoi_level   = eoi_valid && tmr_q[isr_top];
        cr_rdata    = tpr_q[VEC_W-1 -: CLASS_W];
        task_prio   = tpr_q;
    end

    // Next-state for the bitmaps; retirement applies before grant/accept.
    always_comb begin
        irr_d = irr_q;
        isr_d = isr_q;
        tmr_d = tmr_q;
        if (eoi_valid) begin
            isr_d[isr_top] = 1'b0;
            tmr_d[isr_top] = 1'b0;
        end
        if (ack_valid) begin
            irr_d[irr_top] = 1'b0;
            isr_d[irr_top] = 1'b1;
        end
        if (acc_ok) begin
            irr_d[acc_vec] = 1'b1;
            tmr_d[acc_vec] = acc_level;
        end
    end

    // Next task priority; full-byte write wins over the class view.
    always_comb begin
        tpr_d = tpr_q;
        if (tpr_wr)
            tpr_d = tpr_wdata;
        else if (cr_wr)
            tpr_d = {cr_wdata, tpr_q[LOW_W-1:0] & KEEP_MASK};
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            tmr_q <= '0;
            tpr_q <= '0;
        end else begin
            irr_q <= irr_d;
            isr_q <= isr_d;
            tmr_q <= tmr_d;
            tpr_q <= tpr_d;
        end
    end

    // After a grant (no retirement), priority is at least the grant's class.
    p_ack_raises_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !eoi) |=>
        ((proc_prio >> LOW_W) >= ($past(ack_vec) >> LOW_W)));

    // A vector just taken cannot be taken again on the next cycle.
    p_dup_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok |=> !(acc_valid && (acc_vec == $past(acc_vec)) && acc_ok));

    // Retirement with nothing in service leaves the priority alone.
    p_idle_eoi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !eoi_valid && !ack_valid && !tpr_wr && !cr_wr) |=>
        $stable(proc_prio));

    // A refused acknowledge leaves priority and in-service state alone.
    p_idle_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !ack_valid && !eoi && !tpr_wr && !cr_wr) |=>
        ($stable(proc_prio) && $stable(eoi_vec)));
endmodule

// File: tb/test_vprio_ctrl.sv
module test_vprio_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1;
    logic       acc_valid = 1'b0, acc_level = 1'b0, acc_ok;
    logic [7:0] acc_vec = '0;
    logic       tpr_wr = 1'b0, cr_wr = 1'b0;
    logic [7:0] tpr_wdata = '0;
    logic [3:0] cr_wdata = '0, cr_rdata;
    logic [7:0] task_prio, proc_prio, offer_vec, ack_vec, eoi_vec;
    logic       offer_valid, ack = 1'b0, ack_valid, eoi = 1'b0, eoi_valid, eoi_level;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    vprio_ctrl i_vprio_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .acc_valid(acc_valid), .acc_vec(acc_vec), .acc_level(acc_level), .acc_ok(acc_ok),
        .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata), .cr_wr(cr_wr), .cr_wdata(cr_wdata),
        .cr_rdata(cr_rdata), .task_prio(task_prio), .proc_prio(proc_prio),
        .offer_valid(offer_valid), .offer_vec(offer_vec),
        .ack(ack), .ack_valid(ack_valid), .ack_vec(ack_vec),
        .eoi(eoi), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .eoi_level(eoi_level));

    localparam logic [2:0] OP_ACC = 3'd0, OP_ACK = 3'd1, OP_EOI = 3'd2,
                           OP_TPR = 3'd3, OP_CR = 3'd4;

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] arg;
        logic       lvl;
        logic       e_ok;
        logic [7:0] e_vec;
        logic       e_lvl;
        logic       e_ov;
        logic [7:0] e_ovec;
        logic [7:0] e_ppr;
        logic [3:0] req;
    } row_t;

    localparam int NROWS = 20;
    localparam row_t TBL [NROWS] = '{
        '{OP_ACC, 8'h45, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 8'h45, 8'h00, 4'd1},  // R1
        '{OP_ACC, 8'h45, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h45, 8'h00, 4'd7},  // R7 duplicate
        '{OP_ACC, 8'h9A, 1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 8'h9A, 8'h00, 4'd1},  // R1 higher word
        '{OP_ACC, 8'h13, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 8'h9A, 8'h00, 4'd1},  // R1
        '{OP_TPR, 8'h9A, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h9A, 4'd4},  // R4 strict
        '{OP_TPR, 8'h8F, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h9A, 8'h8F, 4'd4},  // R4
        '{OP_ACK, 8'h00, 1'b0, 1'b1, 8'h9A, 1'b0, 1'b0, 8'h00, 8'h90, 4'd5},  // R5
        '{OP_ACK, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h90, 4'd6},  // R6
        '{OP_TPR, 8'h20, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h90, 4'd2},  // R2
        '{OP_TPR, 8'hA3, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 8'hA3, 4'd2},  // R2
        '{OP_TPR, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h90, 4'd2},  // R2
        '{OP_EOI, 8'h00, 1'b0, 1'b1, 8'h9A, 1'b1, 1'b1, 8'h45, 8'h00, 4'd9},  // R9 level
        '{OP_ACC, 8'h9A, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 8'h9A, 8'h00, 4'd7},  // R7 re-accept edge
        '{OP_ACK, 8'h00, 1'b0, 1'b1, 8'h9A, 1'b0, 1'b0, 8'h00, 8'h90, 4'd5},  // R5
        '{OP_EOI, 8'h00, 1'b0, 1'b1, 8'h9A, 1'b0, 1'b1, 8'h45, 8'h00, 4'd9},  // R9 edge
        '{OP_EOI, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h45, 8'h00, 4'd8},  // R8
        '{OP_ACK, 8'h00, 1'b0, 1'b1, 8'h45, 1'b0, 1'b0, 8'h00, 8'h40, 4'd5},  // R5
        '{OP_CR,  8'h03, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h40, 4'd10}, // R10
        '{OP_EOI, 8'h00, 1'b0, 1'b1, 8'h45, 1'b0, 1'b0, 8'h00, 8'h30, 4'd3},  // R3, R7 still edge
        '{OP_CR,  8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h13, 8'h00, 4'd3}   // R3
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One operation: drive at negedge, sample combinational results, clock it.
    task automatic apply(input logic [2:0] op, input logic [7:0] arg, input logic lvl,
                         output logic g_ok, output logic [7:0] g_vec, output logic g_lvl);
        @(negedge clk);
        case (op)
            OP_ACC: begin acc_valid = 1'b1; acc_vec = arg; acc_level = lvl; end
            OP_ACK: ack = 1'b1;
            OP_EOI: eoi = 1'b1;
            OP_TPR: begin tpr_wr = 1'b1; tpr_wdata = arg; end
            default: begin cr_wr = 1'b1; cr_wdata = arg[3:0]; end
        endcase
        #5;
        g_ok  = (op == OP_ACC) ? acc_ok : (op == OP_ACK) ? ack_valid : eoi_valid;
        g_vec = (op == OP_ACK) ? ack_vec : eoi_vec;
        g_lvl = eoi_level;
        @(posedge clk);
        #2;
        acc_valid = 1'b0; ack = 1'b0; eoi = 1'b0; tpr_wr = 1'b0; cr_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #2;
        rst_n = 1'b1;
    endtask

    logic g_ok, g_lvl;
    logic [7:0] g_vec;
    logic done = 1'b0;

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R12 reset state
        check("R12 offer_valid", offer_valid, 0);
        check("R12 proc_prio", proc_prio, 0);
        check("R12 task_prio", task_prio, 0);
        check("R12 cr_rdata", cr_rdata, 0);

        for (int i = 0; i < NROWS; i++) begin
            string tag;
            tag = $sformatf("R%0d row %0d", TBL[i].req, i);
            apply(TBL[i].op, TBL[i].arg, TBL[i].lvl, g_ok, g_vec, g_lvl);
            if (TBL[i].op == OP_ACC || TBL[i].op == OP_ACK || TBL[i].op == OP_EOI) begin
                check({tag, " flag"}, g_ok, TBL[i].e_ok);
                if (TBL[i].op != OP_ACC && TBL[i].e_ok)
                    check({tag, " vector"}, g_vec, TBL[i].e_vec);
                if (TBL[i].op == OP_EOI && TBL[i].e_ok)
                    check({tag, " trigger"}, g_lvl, TBL[i].e_lvl);
            end
            check({tag, " offer_valid"}, offer_valid, TBL[i].e_ov);
            if (TBL[i].e_ov)
                check({tag, " offer_vec"}, offer_vec, TBL[i].e_ovec);
            check({tag, " proc_prio"}, proc_prio, TBL[i].e_ppr);
        end

        // R10 class view keeps bit 2 only
        apply(OP_TPR, 8'h57, 1'b0, g_ok, g_vec, g_lvl);
        apply(OP_CR, 8'h0C, 1'b0, g_ok, g_vec, g_lvl);
        check("R10 task_prio keep bit2", task_prio, 8'hC4);
        check("R10 cr_rdata", cr_rdata, 4'hC);
        apply(OP_TPR, 8'h5B, 1'b0, g_ok, g_vec, g_lvl);
        apply(OP_CR, 8'h02, 1'b0, g_ok, g_vec, g_lvl);
        check("R10 task_prio bit2 clear", task_prio, 8'h20);

        // R12 reset mid-run clears pending and priority
        do_reset();
        check("R12 pending cleared", offer_valid, 0);
        check("R12 task_prio cleared", task_prio, 0);
        apply(OP_EOI, 8'h00, 1'b0, g_ok, g_vec, g_lvl);
        check("R12 in-service cleared", g_ok, 0);

        // R1 word boundary and top vector
        apply(OP_ACC, 8'h1F, 1'b0, g_ok, g_vec, g_lvl);
        apply(OP_ACC, 8'h20, 1'b0, g_ok, g_vec, g_lvl);
        check("R1 boundary offer", offer_vec, 8'h20);
        apply(OP_ACC, 8'hFF, 1'b0, g_ok, g_vec, g_lvl);
        check("R1 top offer", offer_vec, 8'hFF);

        // R11 disabled: no offer, no grant, accepts refused
        @(negedge clk); enable = 1'b0;
        #2;
        check("R11 offer masked", offer_valid, 0);
        apply(OP_ACK, 8'h00, 1'b0, g_ok, g_vec, g_lvl);
        check("R11 ack refused", g_ok, 0);
        apply(OP_ACC, 8'h70, 1'b0, g_ok, g_vec, g_lvl);
        check("R11 accept refused", g_ok, 0);
        @(negedge clk); enable = 1'b1;
        #2;
        check("R11 offer restored", offer_vec, 8'hFF);
        apply(OP_ACK, 8'h00, 1'b0, g_ok, g_vec, g_lvl);
        check("R11 ack top", g_vec, 8'hFF);
        apply(OP_EOI, 8'h00, 1'b0, g_ok, g_vec, g_lvl);
        apply(OP_ACK, 8'h00, 1'b0, g_ok, g_vec, g_lvl);
        check("R11 refused vector absent", g_vec, 8'h20);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule